// File: doc/BRIEF.md
# Dual-Mode Converter Sample Formatter

This block takes the parallel output of a dual-channel 8-bit converter interface that has already been deserialized into the core clock domain. On every core cycle it receives four samples from the I channel and four from the Q channel, each with an over-range flag, plus one sync marker per sample pair. The raw offset-binary codes become signed 8-bit fractions with seven fractional bits, so the values run from -1 up to, but not including, +1.

A runtime view select sets the lane order on the eight-slot output bus. In single-stream view the two channels are taken to sample alternately, and the slots hold one time-ordered stream of eight samples. In two-stream view the lower four slots hold the I samples and the upper four the Q samples. The block also gives a per-cycle out-of-range flag, delayed sync taps and a data-valid strobe thinned by a programmable sample period. Every output has a fixed latency of two core cycles, so sync and valid stay aligned with the data they describe.

Top module: `adc_capture_fmt`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: Each output sample equals its raw code with the most significant bit inverted, so raw 0x00 gives 0x80 (-1.0), 0x80 gives 0x00 and 0xFF gives 0x7F.
- R3: With `dual_mode` high, output slot k (bits [8k+7:8k]) for k in 0..3 holds I lane k, and slot 4+k holds Q lane k.
- R4: With `dual_mode` low, slot 2k holds I lane k and slot 2k+1 holds Q lane k, so the slots run in time order I0, Q0, I1, Q1, I2, Q2, I3, Q3.
- R5: Every output reflects the inputs, `dual_mode` included, that were sampled exactly two rising edges earlier. A change of view therefore takes effect with its own data.
- R6: `oor_out` is the OR of all eight over-range bits that came with the presented samples.
- R7: `sync_out[X]` equals `sync_in[X]` from two cycles earlier. Bit X marks sample pair X, which is stream offset X in two-stream view and offset 2X in single-stream view.
- R8: With a sample period N of 2 or more held constant, `dv_out` is high on exactly one cycle in every N. A period of 0 or 1 keeps `dv_out` high on every cycle.
- R9: The period counter starts at zero when reset is released and restarts whenever `period` changes. The cycle just after a change, or just after reset, is a valid cycle, and it appears on `dv_out` two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| dual_mode | input | 1 | 1 selects the two-stream view, 0 selects the single-stream view |
| period | input | PW | Sample period N for the valid strobe |
| raw_i | input | LANES*SW | I-channel offset-binary codes, lane k in bits [SW*k+SW-1:SW*k] |
| raw_q | input | LANES*SW | Q-channel offset-binary codes, same lane layout |
| ovr_i | input | LANES | Over-range flag per I lane |
| ovr_q | input | LANES | Over-range flag per Q lane |
| sync_in | input | LANES | Sync marker per sample pair |
| smp_out | output | 2*LANES*SW | Eight formatted sample slots |
| oor_out | output | 1 | Any sample in this output word is over range |
| sync_out | output | LANES | Delayed sync taps |
| dv_out | output | 1 | Output word is valid for the chosen period |

## Verification
Random codes in each view on its own check the two lane orders. Distinct values in every lane mean that a swapped I/Q pair or a misplaced slot changes the result. Fixed boundary codes (0x00, 0x7F, 0x80, 0xFF) test the MSB inversion at its edges. Switching the view on every cycle separates a view select that travels with its data from one applied a stage too early or too late. Walking single over-range and sync bits catch a dropped lane in the OR and a shifted tap. Several periods, with changes made in the middle of a count, test the decimation and the restart of the counter.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  // Lane arrangement on the output slot bus.
  typedef enum logic {
    VIEW_SINGLE = 1'b0,  // one interleaved stream, time ordered
    VIEW_DUAL   = 1'b1   // I lanes low half, Q lanes high half
  } view_e;

endpackage

// File: rtl/adc_lane_fmt.sv
// Offset binary to two's complement per lane, plus the over-range reduction.
module adc_lane_fmt #(
  parameter int LANES = 4,
  parameter int SW    = 8
) (
  input  logic [LANES*SW-1:0] raw_i,
  input  logic [LANES*SW-1:0] raw_q,
  input  logic [LANES-1:0]    ovr_i,
  input  logic [LANES-1:0]    ovr_q,
  output logic [LANES*SW-1:0] fmt_i,
  output logic [LANES*SW-1:0] fmt_q,
  output logic                ovr_any
);

  localparam int MSB = SW - 1;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign fmt_i[k*SW+MSB]    = ~raw_i[k*SW+MSB];
    assign fmt_i[k*SW +: MSB] =  raw_i[k*SW +: MSB];
    assign fmt_q[k*SW+MSB]    = ~raw_q[k*SW+MSB];
    assign fmt_q[k*SW +: MSB] =  raw_q[k*SW +: MSB];
  end

  assign ovr_any = |{ovr_i, ovr_q};

endmodule

// File: rtl/adc_lane_order.sv
// Builds both slot arrangements and selects one.
module adc_lane_order
  import adc_fmt_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SW    = 8
) (
  input  view_e                 view,
  input  logic [LANES*SW-1:0]   lane_i,
  input  logic [LANES*SW-1:0]   lane_q,
  output logic [2*LANES*SW-1:0] slots
);

  localparam int OW = 2 * LANES * SW;

  logic [OW-1:0] dual_v;
  logic [OW-1:0] single_v;

  for (genvar k = 0; k < LANES; k++) begin : g_slot
    assign dual_v[k*SW +: SW]           = lane_i[k*SW +: SW];
    assign dual_v[(LANES+k)*SW +: SW]   = lane_q[k*SW +: SW];
    assign single_v[(2*k)*SW +: SW]     = lane_i[k*SW +: SW];
    assign single_v[(2*k+1)*SW +: SW]   = lane_q[k*SW +: SW];
  end

  assign slots = (view == VIEW_DUAL) ? dual_v : single_v;

endmodule

// File: rtl/adc_rate_gen.sv
// Sample-period counter: tick when count is zero, restart on period change.
module adc_rate_gen #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period,
  output logic          tick
);

  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] per_q, per_d;
  logic          cnt_en;
  logic          per_chg;
  logic          wrap;

  assign cnt_en  = 1'b1;
  assign per_chg = (period != per_q);
  assign wrap    = (period <= ONE) || (cnt_q >= period - ONE);
  assign tick    = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q + ONE;
    if (per_chg || wrap) begin
      cnt_d = '0;
    end
    per_d = period;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

endmodule

// File: rtl/adc_capture_fmt.sv
// Two-stage formatter: stage 1 captures converted lanes, stage 2 orders them.
module adc_capture_fmt
  import adc_fmt_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SW    = 8,
  parameter int PW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dual_mode,
  input  logic [PW-1:0]         period,
  input  logic [LANES*SW-1:0]   raw_i,
  input  logic [LANES*SW-1:0]   raw_q,
  input  logic [LANES-1:0]      ovr_i,
  input  logic [LANES-1:0]      ovr_q,
  input  logic [LANES-1:0]      sync_in,
  output logic [2*LANES*SW-1:0] smp_out,
  output logic                  oor_out,
  output logic [LANES-1:0]      sync_out,
  output logic                  dv_out
);

  localparam int LW = LANES * SW;
  localparam int OW = 2 * LW;

  logic          pipe_en;
  logic [LW-1:0] fmt_i, fmt_q;
  logic          ovr_any;
  logic          rate_tick;
  logic [OW-1:0] ord_slots;

  // stage 1
  logic [LW-1:0]    s1_i_q, s1_i_d;
  logic [LW-1:0]    s1_q_q, s1_q_d;
  logic             s1_ovr_q, s1_ovr_d;
  logic [LANES-1:0] s1_sync_q, s1_sync_d;
  logic             s1_tick_q, s1_tick_d;
  view_e            s1_view_q, s1_view_d;

  // stage 2
  logic [OW-1:0]    s2_smp_d;
  logic             s2_ovr_d;
  logic [LANES-1:0] s2_sync_d;
  logic             s2_dv_d;

  assign pipe_en = 1'b1;

  adc_lane_fmt #(.LANES(LANES), .SW(SW)) u_fmt (
    .raw_i   (raw_i),
    .raw_q   (raw_q),
    .ovr_i   (ovr_i),
    .ovr_q   (ovr_q),
    .fmt_i   (fmt_i),
    .fmt_q   (fmt_q),
    .ovr_any (ovr_any)
  );

  adc_rate_gen #(.PW(PW)) u_rate (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (period),
    .tick   (rate_tick)
  );

  always_comb begin
    s1_i_d    = fmt_i;
    s1_q_d    = fmt_q;
    s1_ovr_d  = ovr_any;
    s1_sync_d = sync_in;
    s1_tick_d = rate_tick;
    s1_view_d = dual_mode ? VIEW_DUAL : VIEW_SINGLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_i_q    <= '0;
      s1_q_q    <= '0;
      s1_ovr_q  <= 1'b0;
      s1_sync_q <= '0;
      s1_tick_q <= 1'b0;
      s1_view_q <= VIEW_SINGLE;
    end else if (pipe_en) begin
      s1_i_q    <= s1_i_d;
      s1_q_q    <= s1_q_d;
      s1_ovr_q  <= s1_ovr_d;
      s1_sync_q <= s1_sync_d;
      s1_tick_q <= s1_tick_d;
      s1_view_q <= s1_view_d;
    end
  end

  adc_lane_order #(.LANES(LANES), .SW(SW)) u_ord (
    .view   (s1_view_q),
    .lane_i (s1_i_q),
    .lane_q (s1_q_q),
    .slots  (ord_slots)
  );

  always_comb begin
    s2_smp_d  = ord_slots;
    s2_ovr_d  = s1_ovr_q;
    s2_sync_d = s1_sync_q;
    s2_dv_d   = s1_tick_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_out  <= '0;
      oor_out  <= 1'b0;
      sync_out <= '0;
      dv_out   <= 1'b0;
    end else if (pipe_en) begin
      smp_out  <= s2_smp_d;
      oor_out  <= s2_ovr_d;
      sync_out <= s2_sync_d;
      dv_out   <= s2_dv_d;
    end
  end

endmodule

// File: rtl/adc_capture_fmt_chk.sv
module adc_capture_fmt_chk #(
  parameter int LANES = 4,
  parameter int SW    = 8,
  parameter int PW    = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dual_mode,
  input logic [PW-1:0]         period,
  input logic [LANES*SW-1:0]   raw_i,
  input logic [LANES-1:0]      ovr_i,
  input logic [LANES-1:0]      ovr_q,
  input logic [LANES-1:0]      sync_in,
  input logic [2*LANES*SW-1:0] smp_out,
  input logic                  oor_out,
  input logic [LANES-1:0]      sync_out,
  input logic                  dv_out
);

  localparam logic [PW-1:0] ONE = PW'(1);

  // Edges seen since reset release, saturating.
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R1: outputs stay zero during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      p_quiet_reset_r1: assert (smp_out == '0 && !oor_out && sync_out == '0 && !dv_out);
    end
  end

  // R2, R3: slot 0 MSB in two-stream view is the inverted I lane 0 MSB
  p_msb_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2 && $past(dual_mode, 2)) |-> smp_out[SW-1] == ~$past(raw_i[SW-1], 2));

  // R6, R5
  p_oor_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2) |-> oor_out == |$past({ovr_i, ovr_q}, 2));

  // R7, R5
  p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2) |-> sync_out == $past(sync_in, 2));

  // R8: period 0 or 1 keeps valid high
  p_dv_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd3 && $past(period, 3) <= ONE) |-> dv_out);

  // R9: a period change yields a valid word
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && $past(period, 3) != $past(period, 4)) |-> dv_out);

endmodule

bind adc_capture_fmt adc_capture_fmt_chk #(.LANES(LANES), .SW(SW), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dual_mode (dual_mode),
  .period    (period),
  .raw_i     (raw_i),
  .ovr_i     (ovr_i),
  .ovr_q     (ovr_q),
  .sync_in   (sync_in),
  .smp_out   (smp_out),
  .oor_out   (oor_out),
  .sync_out  (sync_out),
  .dv_out    (dv_out)
);

// File: tb/sim_adc_capture_fmt.sv
`timescale 1ns/1ps
module sim_adc_capture_fmt;

  logic        clk;
  logic        rst_n;
  logic        dual_mode;
  logic [7:0]  period;
  logic [31:0] raw_i, raw_q;
  logic [3:0]  ovr_i, ovr_q, sync_in;
  logic [63:0] smp_out;
  logic        oor_out;
  logic [3:0]  sync_out;
  logic        dv_out;

  adc_capture_fmt u0 (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .period(period),
    .raw_i(raw_i), .raw_q(raw_q), .ovr_i(ovr_i), .ovr_q(ovr_q),
    .sync_in(sync_in), .smp_out(smp_out), .oor_out(oor_out),
    .sync_out(sync_out), .dv_out(dv_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [63:0] smp;
    logic        oor;
    logic [3:0]  sync;
    logic        dv;
  } exp_t;

  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;
  int   wd    = 0;
  exp_t exp_q[$];
  exp_t cur_exp;
  int   m_cnt;
  int   m_perq;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [7:0] cvt(input logic [7:0] r);
    return r ^ 8'h80;
  endfunction

  // Behavioural model: expected word computed at each capturing edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt  = 0;
      m_perq = 0;
      exp_q.delete();
      exp_q.push_back('0);
      cur_exp = '0;
    end else begin
      exp_t e;
      e = '0;
      for (int m = 0; m < 8; m++) begin
        logic [7:0] v;
        if (dual_mode) v = (m < 4) ? raw_i[m*8 +: 8] : raw_q[(m-4)*8 +: 8];
        else           v = (m % 2 == 0) ? raw_i[(m/2)*8 +: 8] : raw_q[(m/2)*8 +: 8];
        e.smp[m*8 +: 8] = cvt(v);
      end
      e.oor  = (ovr_i != 0) || (ovr_q != 0);
      e.sync = sync_in;
      e.dv   = (m_cnt == 0);
      if (int'(period) != m_perq) m_cnt = 0;
      else if (period <= 1 || m_cnt >= int'(period) - 1) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      m_perq = int'(period);
      exp_q.push_back(e);
      cur_exp = exp_q.pop_front();
    end
  end

  // Compare away from the capturing edge.
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R1 reset outputs", {smp_out}, 64'h0);
        chk("R1 reset flags", {59'h0, oor_out, sync_out}, 64'h0);
        chk("R1 reset valid", {63'h0, dv_out}, 64'h0);
      end else begin
        chk("R2 R3 R4 R5 sample slots", smp_out, cur_exp.smp);
        chk("R6 R5 out-of-range", {63'h0, oor_out}, {63'h0, cur_exp.oor});
        chk("R7 R5 sync taps", {60'h0, sync_out}, {60'h0, cur_exp.sync});
        chk("R8 R9 data valid", {63'h0, dv_out}, {63'h0, cur_exp.dv});
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<150000", wd);
      finish_up();
    end
  end

  task automatic drive(input bit dm, input int per, input logic [31:0] ri, input logic [31:0] rq,
                       input logic [3:0] oi, input logic [3:0] oq, input logic [3:0] sy);
    @(negedge clk);
    dual_mode = dm;
    period    = per[7:0];
    raw_i     = ri;
    raw_q     = rq;
    ovr_i     = oi;
    ovr_q     = oq;
    sync_in   = sy;
  endtask

  task automatic rnd(input bit dm, input int per, input int n);
    for (int c = 0; c < n; c++)
      drive(dm, per, $urandom, $urandom, 4'h0, 4'h0, 4'($urandom) & 4'h1);
  endtask

  initial begin
    rst_n = 0; dual_mode = 0; period = 0;
    raw_i = 0; raw_q = 0; ovr_i = 0; ovr_q = 0; sync_in = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R3: two-stream view, random lanes
    rnd(1'b1, 1, 30);
    // R4: single-stream view
    rnd(1'b0, 1, 30);
    // R2: boundary codes in both views
    for (int v = 0; v < 2; v++) begin
      drive(v[0], 1, 32'h00FF807F, 32'h7F80FF00, 0, 0, 0);
      drive(v[0], 1, 32'hFFFFFFFF, 32'h00000000, 0, 0, 0);
      drive(v[0], 1, 32'h80808080, 32'h7F7F7F7F, 0, 0, 0);
      drive(v[0], 1, 32'h03020100, 32'h13121110, 0, 0, 0);
    end
    // R5: view toggling each cycle
    for (int c = 0; c < 30; c++)
      drive(c[0], 1, $urandom, $urandom, 0, 0, 0);
    // R6, R7: walking single bits
    for (int b = 0; b < 8; b++) begin
      logic [7:0] oh;
      oh = 8'h1 << b;
      drive(b[1], 0, $urandom, $urandom, oh[3:0], oh[7:4], oh[3:0]);
      drive(b[1], 0, $urandom, $urandom, 0, 0, 0);
    end
    // R8: several periods
    rnd(1'b1, 2, 12);
    rnd(1'b0, 3, 15);
    rnd(1'b1, 5, 25);
    rnd(1'b0, 0, 8);
    // R9: changes mid-count
    rnd(1'b1, 4, 6);
    rnd(1'b1, 3, 2);
    rnd(1'b0, 7, 10);
    rnd(1'b0, 2, 1);
    rnd(1'b0, 6, 20);
    rnd(1'b1, 1, 4);
    repeat (4) drive(1'b0, 1, 0, 0, 0, 0, 0);
    finish_up();
  end

endmodule